// File: doc/BRIEF.md
# Latched Three-Port Bus Exchanger

This block moves 12-bit words between a single A port and two B ports, 1B and 2B. It is meant for memory interleaving, where one word from A is captured toward two banks, and for address multiplexing, where two B-side sources take turns driving A. Each directional path has its own level-sensitive latch, so four paths run independently: A to 1B, A to 2B, 1B to A and 2B to A. A select input chooses which of the two return latches reaches the A output.

Each port is modelled as a separate input bus, output bus and output-enable flag, so no tri-state nets are needed. The latches are clocked equivalents of transparent latches. While an enable is high, the path output follows its input in the same cycle and the stored copy is refreshed on every clock edge. While the enable is low, the output shows the value present in the last clock cycle in which the enable was high. An asynchronous active-low reset clears all four stored copies.

The block has no state machine beyond the four holding registers. The only "states" are transparent (enable high) and holding (enable low) for each path. The only transitions are the falling enable, which captures a value, and the rising enable, which releases the path.

Top module: `bus_exchanger3`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after reset with all latch enables low, every data output (`a_o`, `b1_o`, `b2_o`) reads zero.
- R2: While `le_a1` is high, `b1_o` equals `a_i` in the same cycle. While `le_a2` is high, `b2_o` equals `a_i` in the same cycle.
- R3: After any latch enable goes low, that path's output keeps the input value from the last clock cycle in which the enable was high, until the enable returns high.
- R4: With `le_a1` and `le_a2` both high, the same `a_i` word is written to both B ports, and both keep it after both enables drop together.
- R5: The 1B-to-A latch (`le_1a`) and the 2B-to-A latch (`le_2a`) are transparent and hold independently of each other.
- R6: `sel` = 1 routes the 1B-to-A latch to `a_o`. `sel` = 0 routes the 2B-to-A latch to `a_o`.
- R7: Each output-enable flag (`a_oe_o`, `b1_oe_o`, `b2_oe_o`) equals its active-high enable input. When a flag is 0, its data output still shows its latch value unchanged.
- R8: One B port can hold a stable value for reading while the other B port's return latch is loaded. The latches on the two sides do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that updates the stored latch copies |
| rst_n | input | 1 | Asynchronous active-low reset, clears the stored copies |
| a_i | input | 12 | Data arriving on the A port |
| a_o | output | 12 | Data driven toward the A port |
| a_oe_o | output | 1 | A-port drive flag |
| b1_i | input | 12 | Data arriving on the 1B port |
| b1_o | output | 12 | Data driven toward the 1B port |
| b1_oe_o | output | 1 | 1B-port drive flag |
| b2_i | input | 12 | Data arriving on the 2B port |
| b2_o | output | 12 | Data driven toward the 2B port |
| b2_oe_o | output | 1 | 2B-port drive flag |
| le_a1 | input | 1 | Enable of the A-to-1B latch, high = transparent |
| le_a2 | input | 1 | Enable of the A-to-2B latch, high = transparent |
| le_1a | input | 1 | Enable of the 1B-to-A latch, high = transparent |
| le_2a | input | 1 | Enable of the 2B-to-A latch, high = transparent |
| sel | input | 1 | Return select, 1 = from 1B, 0 = from 2B |
| oe_a | input | 1 | A-port output enable, active high |
| oe_b1 | input | 1 | 1B-port output enable, active high |
| oe_b2 | input | 1 | 2B-port output enable, active high |

## Verification
The assertions assume that all inputs change only between clock edges and stay steady across each rising edge. This makes the "last high cycle" captured on a falling enable well defined. The bench therefore drives every input one nanosecond after the rising edge and samples outputs at the falling edge. The assertions also assume that reset is held for at least one edge. The bench asserts reset across several edges before releasing it between edges.

// File: rtl/bxchg_pkg.sv
package bxchg_pkg;
    localparam int unsigned BX_WIDTH = 12;
    typedef logic [BX_WIDTH-1:0] bx_word_t;
endpackage

// File: rtl/bxchg_path_latch.sv
module bxchg_path_latch #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    // stored copy refreshed on every edge while transparent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= d;
        end
    end

    always_comb begin
        q = le ? d : held_q;
    end

    // R3: first low cycle shows the word of the last high cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> (q == $past(d)));

    // R3: a closed latch does not move
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le)) |-> $stable(q));
endmodule

// File: rtl/bxchg_return_mux.sv
module bxchg_return_mux #(
    parameter int unsigned W = 12
) (
    input  logic         sel,
    input  logic [W-1:0] from_b1,
    input  logic [W-1:0] from_b2,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            1'b1:    y = from_b1;
            default: y = from_b2;
        endcase
    end
endmodule

// File: rtl/bus_exchanger3.sv
module bus_exchanger3 #(
    parameter int unsigned W = bxchg_pkg::BX_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe_o,
    input  logic [W-1:0] b1_i,
    output logic [W-1:0] b1_o,
    output logic         b1_oe_o,
    input  logic [W-1:0] b2_i,
    output logic [W-1:0] b2_o,
    output logic         b2_oe_o,
    input  logic         le_a1,
    input  logic         le_a2,
    input  logic         le_1a,
    input  logic         le_2a,
    input  logic         sel,
    input  logic         oe_a,
    input  logic         oe_b1,
    input  logic         oe_b2
);
    localparam int unsigned NB = 2;

    logic [NB-1:0]        out_le;
    logic [NB-1:0]        ret_le;
    logic [NB-1:0][W-1:0] ret_d;
    logic [NB-1:0][W-1:0] out_q;
    logic [NB-1:0][W-1:0] ret_q;

    assign out_le = {le_a2, le_a1};
    assign ret_le = {le_2a, le_1a};
    assign ret_d  = {b2_i, b1_i};

    for (genvar g = 0; g < NB; g++) begin : g_side
        bxchg_path_latch #(.W(W)) u_out (
            .clk(clk), .rst_n(rst_n), .le(out_le[g]), .d(a_i), .q(out_q[g])
        );
        bxchg_path_latch #(.W(W)) u_ret (
            .clk(clk), .rst_n(rst_n), .le(ret_le[g]), .d(ret_d[g]), .q(ret_q[g])
        );
    end

    bxchg_return_mux #(.W(W)) u_mux (
        .sel(sel), .from_b1(ret_q[0]), .from_b2(ret_q[1]), .y(a_o)
    );

    assign b1_o    = out_q[0];
    assign b2_o    = out_q[1];
    assign a_oe_o  = oe_a;
    assign b1_oe_o = oe_b1;
    assign b2_oe_o = oe_b2;

    // R6: select routes the open return path to A
    p_sel1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && le_1a) |-> (a_o == b1_i));
    p_sel0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && le_2a) |-> (a_o == b2_i));
    // R2: open forward path follows A
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        le_a1 |-> (b1_o == a_i));
    // R4: both forward paths open carry the same word
    p_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a1 && le_a2) |-> (b1_o == b2_o));
    // R7: dropping a drive flag leaves a closed path's data unchanged
    p_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_b1) && !le_a1 && $past(!le_a1)) |-> $stable(b1_o));
endmodule

// File: tb/tb_bus_exchanger3.sv
`timescale 1ns/1ps
module tb_bus_exchanger3;
    localparam int W = 12;
    logic clk = 0, rst_n = 0;
    logic [W-1:0] a_i = 0, b1_i = 0, b2_i = 0;
    logic le_a1 = 0, le_a2 = 0, le_1a = 0, le_2a = 0, sel = 0;
    logic oe_a = 0, oe_b1 = 0, oe_b2 = 0;
    logic [W-1:0] a_o, b1_o, b2_o;
    logic a_oe_o, b1_oe_o, b2_oe_o;
    int checks = 0, fails = 0;
    logic [W-1:0] m1 = 0, m2 = 0, m1a = 0, m2a = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    bus_exchanger3 dut (.*);

    // reference: stored copies
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin m1 = 0; m2 = 0; m1a = 0; m2a = 0; end
        else begin
            if (le_a1) m1 = a_i;
            if (le_a2) m2 = a_i;
            if (le_1a) m1a = b1_i;
            if (le_2a) m2a = b2_i;
        end
    end

    task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [W-1:0] e1, e2, ea;
        e1 = le_a1 ? a_i : m1;
        e2 = le_a2 ? a_i : m2;
        ea = sel ? (le_1a ? b1_i : m1a) : (le_2a ? b2_i : m2a);
        chk(tag, b1_o, e1);
        chk(tag, b2_o, e2);
        chk(tag, a_o, ea);
        chk("R7", {9'd0, a_oe_o, b1_oe_o, b2_oe_o}, {9'd0, oe_a, oe_b1, oe_b2});
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        fork
            begin
                // R1 reset
                tag = "R1";
                a_i = 12'hABC; b1_i = 12'h123; b2_i = 12'h456;
                step(3);
                rst_n = 1;
                step(2);
                // R2 transparency
                tag = "R2";
                le_a1 = 1; a_i = 12'h5A5; step(1);
                a_i = 12'h0F0; step(1);
                le_a1 = 0; le_a2 = 1; a_i = 12'h777; step(1);
                // R3 hold
                tag = "R3";
                le_a2 = 0; a_i = 12'hFFF; step(3);
                // R4 both at once
                tag = "R4";
                le_a1 = 1; le_a2 = 1; a_i = 12'h9C3; step(1);
                le_a1 = 0; le_a2 = 0; a_i = 12'h000; step(2);
                // R5 / R6 return paths and select
                tag = "R5";
                le_1a = 1; b1_i = 12'h111; le_2a = 1; b2_i = 12'h222; sel = 1; step(1);
                le_1a = 0; b1_i = 12'h333; step(1);
                tag = "R6";
                sel = 0; step(1);
                le_2a = 0; b2_i = 12'h444; step(1);
                sel = 1; step(1);
                // R7 drive flags do not gate data
                tag = "R7";
                oe_a = 1; oe_b1 = 1; step(1);
                oe_b1 = 0; oe_b2 = 1; step(1);
                oe_a = 0; step(1);
                // R8 read 1B while loading 2B return
                tag = "R8";
                oe_b1 = 1; le_2a = 1; b2_i = 12'hBEE; sel = 0; step(1);
                le_2a = 0; b2_i = 12'h000; step(2);
                // random mix
                tag = "R3";
                for (int i = 0; i < 400; i++) begin
                    {le_a1, le_a2, le_1a, le_2a, sel, oe_a, oe_b1, oe_b2} = 8'($urandom);
                    a_i = 12'($urandom); b1_i = 12'($urandom); b2_i = 12'($urandom);
                    step(1);
                end
                // R1 reset mid-run clears held words
                tag = "R1";
                le_a1 = 0; le_a2 = 0; le_1a = 0; le_2a = 0;
                rst_n = 0; step(2); rst_n = 1; step(2);
            end
            begin
                repeat (5000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule